// File: doc/BRIEF.md
# Keyed-Reset Watchdog Timer

This block is an 8-bit up-counting watchdog. Software sets it running through a byte-wide control register. It then services it by rewriting the count register, usually to zero, before the count wraps. The counter advances on a one-cycle enable strobe from an external prescaler. If the count wraps from 0xFF to 0x00 while the block is in watchdog mode and enabled, three things happen. A sticky overflow flag is set. A fixed-length overflow pulse goes out of the block. Optionally, a longer internal reset pulse is raised, of power-on or manual type.

The reset control register cannot be written with ordinary byte stores. It accepts only 16-bit word writes whose upper byte is a key:

- One key clears the overflow flag.
- A second key loads the reset-enable and reset-type bits from the lower byte.

Every other write aimed at that register is dropped. A synchronous external reset input takes priority over everything in the block, including an overflow in the same cycle.

Reads are byte-wide and combinational on the offset. Control/status is at offset 0, the counter at offset 1 and reset control at offset 3. Offset 2 reads as zero and is where the keyed word writes land.

Top module: `wdt_keyed_top`

## Requirements
- R1: After reset, every register reads 0x00 and ovf_out, irst_out and irst_manual are low.
- R2: A byte write at offset 0 loads bit 6 (1 = watchdog mode, 0 = interval mode) and bit 5 (1 = count enabled). A byte write at offset 1 loads the counter. Reads return {0, mode, enable, 00000} at offset 0, the count at offset 1, {flag, reset-enable, reset-type, 00000} at offset 3, and 0x00 at offset 2.
- R3: The counter adds one on each tick while enabled and holds while disabled. A counter write in the same cycle as a tick takes the written value.
- R4: A tick with count 0xFF wraps the count to 0x00. If mode and enable are both 1, it also sets the flag (bit 7 at offset 3). In interval mode the wrap sets no flag and produces no pulse.
- R5: An overflow drives ovf_out high for exactly 128 cycles, starting in the cycle after the overflowing tick.
- R6: If reset-enable is 1 at overflow, irst_out rises in the same cycle as ovf_out and stays high for exactly 512 cycles. During that pulse, irst_manual holds the reset-type bit as it was at overflow (0 = power-on, 1 = manual). With reset-enable 0, irst_out stays low.
- R7: A word write at offset 2 with data 0xA500 clears the flag and leaves reset-enable and reset-type unchanged.
- R8: A word write at offset 2 with upper byte 0x5A copies lower bit 6 into reset-enable and bit 5 into reset-type, leaving the flag unchanged.
- R9: The following writes change no register:
  - byte writes at offsets 2 and 3;
  - word writes at offset 2 with any other upper byte;
  - word writes with upper byte 0xA5 and a non-zero lower byte;
  - word writes at offsets 0, 1 and 3.
- R10: While ext_rst is high, all registers are cleared and both pulses end. This holds even if an overflow happens in the same cycle.
- R11: Writes can never set the flag. An overflow in the same cycle as a 0xA500 clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| ext_rst | input | 1 | Synchronous external reset, highest priority |
| tick | input | 1 | Count-enable strobe from the prescaler |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 = write access |
| bus_word | input | 1 | 1 = 16-bit word write, 0 = byte write |
| bus_addr | input | 2 | Byte offset of the access |
| bus_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| bus_rdata | output | 8 | Read data for the current offset |
| ovf_out | output | 1 | Overflow pulse |
| irst_out | output | 1 | Internal reset pulse |
| irst_manual | output | 1 | Reset type: 0 power-on, 1 manual |

## Verification
The bench attacks the key decode with near-miss writes: a byte store to the key offset, an unknown upper byte, the clear key with a non-zero low byte, and a correct key at the wrong offset. A decoder that checks only the upper byte, or ignores access size, would change the flag or the reset configuration. Overflows are made to collide with a flag-clear write and with the external reset in the same cycle. A design with the wrong priority would leave the flag clear in the first case, or fire a pulse in the second. Both pulse lengths are counted edge to edge, and their start cycles are compared. An off-by-one counter, or a reset pulse lagging the overflow pulse, shows up as a count mismatch. Interval-mode wraps and disabled reset confirm that no pulse leaks when it should not.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [1:0] {
    OFS_CTRL = 2'd0,
    OFS_CNT  = 2'd1,
    OFS_KEY  = 2'd2,
    OFS_RCTL = 2'd3
  } ofs_e;

  localparam logic [BYTE_W-1:0] KEY_CLR = 8'hA5;
  localparam logic [BYTE_W-1:0] KEY_CFG = 8'h5A;

  localparam int BIT_MODE = 6;
  localparam int BIT_RUN  = 5;
  localparam int BIT_FLAG = 7;
  localparam int BIT_REN  = 6;
  localparam int BIT_RSEL = 5;

  typedef struct packed {
    logic wdog;
    logic run;
  } tctl_t;

  typedef struct packed {
    logic flag;
    logic ren;
    logic rsel;
  } rctl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_word,
  input  logic [1:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [BYTE_W-1:0] cnt_q,
  input  logic              ovf_evt,
  output tctl_t             tctl,
  output rctl_t             rctl,
  output logic              cnt_load,
  output logic [BYTE_W-1:0] cnt_ldata,
  output logic [BYTE_W-1:0] bus_rdata
);
  logic [BYTE_W-1:0] lo, hi;
  logic byte_wr, word_wr, ctl_wr, key_wr, clr_hit, cfg_hit;
  tctl_t tctl_d;
  rctl_t rctl_d;

  assign lo      = bus_wdata[BYTE_W-1:0];
  assign hi      = bus_wdata[WORD_W-1:BYTE_W];
  assign byte_wr = bus_sel && bus_wr && !bus_word;
  assign word_wr = bus_sel && bus_wr && bus_word;
  assign ctl_wr  = byte_wr && (ofs_e'(bus_addr) == OFS_CTRL);
  assign key_wr  = word_wr && (ofs_e'(bus_addr) == OFS_KEY);
  assign clr_hit = key_wr && (hi == KEY_CLR) && (lo == '0);
  assign cfg_hit = key_wr && (hi == KEY_CFG);

  assign cnt_load  = byte_wr && (ofs_e'(bus_addr) == OFS_CNT);
  assign cnt_ldata = lo;

  // next-state for control/status
  always_comb begin
    tctl_d = tctl;
    if (ext_rst) begin
      tctl_d = '0;
    end else if (ctl_wr) begin
      tctl_d.wdog = lo[BIT_MODE];
      tctl_d.run  = lo[BIT_RUN];
    end
  end

  // next-state for reset control: clear key first, overflow set wins
  always_comb begin
    rctl_d = rctl;
    if (ext_rst) begin
      rctl_d = '0;
    end else begin
      if (clr_hit) rctl_d.flag = 1'b0;
      if (cfg_hit) begin
        rctl_d.ren  = lo[BIT_REN];
        rctl_d.rsel = lo[BIT_RSEL];
      end
      if (ovf_evt) rctl_d.flag = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tctl <= '0;
      rctl <= '0;
    end else begin
      tctl <= tctl_d;
      rctl <= rctl_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (ofs_e'(bus_addr))
      OFS_CTRL: begin
        bus_rdata[BIT_MODE] = tctl.wdog;
        bus_rdata[BIT_RUN]  = tctl.run;
      end
      OFS_CNT:  bus_rdata = cnt_q;
      OFS_KEY:  bus_rdata = '0;
      OFS_RCTL: begin
        bus_rdata[BIT_FLAG] = rctl.flag;
        bus_rdata[BIT_REN]  = rctl.ren;
        bus_rdata[BIT_RSEL] = rctl.rsel;
      end
      default:  bus_rdata = '0;
    endcase
  end

  p_clr_keeps_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit && !ext_rst |=> $stable({rctl.ren, rctl.rsel}));
  p_clr_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit && !ovf_evt && !ext_rst |=> !rctl.flag);
  p_cfg_keeps_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hit && !ovf_evt && !ext_rst |=> rctl.flag == $past(rctl.flag));
  p_unkeyed_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_wr && !ovf_evt && !ext_rst &&
    (!bus_word || bus_addr != 2'd2 ||
     (bus_wdata[15:8] != 8'h5A && !(bus_wdata[15:8] == 8'hA5 && bus_wdata[7:0] == 8'h00)))
    |=> $stable(rctl));
  p_flag_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt && !ext_rst |=> rctl.flag);
  p_ext_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst |=> (rctl == '0) && (tctl == '0));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_rst,
  input  logic              tick,
  input  logic              run,
  input  logic              wdog,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  output logic [BYTE_W-1:0] cnt_q,
  output logic              ovf_evt
);
  localparam logic [BYTE_W-1:0] CNT_MAX = '1;

  logic [BYTE_W-1:0] cnt_d;
  logic step;

  assign step    = tick && run && !load;
  assign ovf_evt = step && wdog && (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (ext_rst)   cnt_d = '0;
    else if (load) cnt_d = load_val;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !load && !ext_rst |=> $stable(cnt_q));
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick && run && !load && !ext_rst |=> cnt_q == BYTE_W'($past(cnt_q) + 1'b1));
  p_load_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load && !ext_rst |=> cnt_q == $past(load_val));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_rst,
  input  logic start,
  output logic active
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (ext_rst)              left_d = '0;
    else if (start)           left_d = CW'(LEN);
    else if (left_q != '0)    left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign active = (left_q != '0);

  p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start && !ext_rst |=> active);
  p_ext_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst |=> !active);
endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
  import wdt_pkg::*;
#(
  parameter int OVF_CYCLES = 128,
  parameter int RST_CYCLES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_rst,
  input  logic        tick,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_word,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        ovf_out,
  output logic        irst_out,
  output logic        irst_manual
);
  tctl_t tctl;
  rctl_t rctl;
  logic cnt_load, ovf_evt, rst_start, type_d;
  logic [BYTE_W-1:0] cnt_ldata, cnt_q;

  wdt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cnt_q(cnt_q), .ovf_evt(ovf_evt),
    .tctl(tctl), .rctl(rctl),
    .cnt_load(cnt_load), .cnt_ldata(cnt_ldata), .bus_rdata(bus_rdata)
  );

  wdt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .tick(tick),
    .run(tctl.run), .wdog(tctl.wdog),
    .load(cnt_load), .load_val(cnt_ldata),
    .cnt_q(cnt_q), .ovf_evt(ovf_evt)
  );

  assign rst_start = ovf_evt && rctl.ren;

  wdt_pulse #(.LEN(OVF_CYCLES)) u_ovf_pulse (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst),
    .start(ovf_evt), .active(ovf_out)
  );

  wdt_pulse #(.LEN(RST_CYCLES)) u_rst_pulse (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst),
    .start(rst_start), .active(irst_out)
  );

  always_comb begin
    type_d = irst_manual;
    if (ext_rst)        type_d = 1'b0;
    else if (rst_start) type_d = rctl.rsel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irst_manual <= 1'b0;
    else        irst_manual <= type_d;
  end

  p_irst_with_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irst_out) |-> $rose(ovf_out));
  p_type_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_start && !ext_rst |=> irst_manual == $past(rctl.rsel));
  p_no_rst_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt && !rctl.ren && !irst_out && !ext_rst |=> !irst_out);
endmodule

// File: tb/sim_wdt_keyed_top.sv
module sim_wdt_keyed_top;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, ext_rst, tick, bus_sel, bus_wr, bus_word;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [7:0]  bus_rdata;
  logic ovf_out, irst_out, irst_manual;

  int errors = 0;
  int checks = 0;
  bit live = 0;

  // behavioural reference state
  int m_mode, m_run, m_cnt, m_flag, m_ren, m_rsel, m_ovf, m_rst, m_type;

  wdt_keyed_top u0 (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .tick(tick),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ovf_out(ovf_out), .irst_out(irst_out), .irst_manual(irst_manual)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_read(input int a);
    case (a)
      0: return (m_mode << 6) | (m_run << 5);
      1: return m_cnt;
      3: return (m_flag << 7) | (m_ren << 6) | (m_rsel << 5);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    int lo, hi;
    bit bw, ww, evt;
    if (!rst_n || ext_rst) begin
      m_mode = 0; m_run = 0; m_cnt = 0; m_flag = 0; m_ren = 0;
      m_rsel = 0; m_ovf = 0; m_rst = 0; m_type = 0;
    end else begin
      bw  = bus_sel && bus_wr && !bus_word;
      ww  = bus_sel && bus_wr && bus_word;
      lo  = int'(bus_wdata[7:0]);
      hi  = int'(bus_wdata[15:8]);
      evt = tick && m_run == 1 && m_mode == 1 && m_cnt == 255 && !(bw && bus_addr == 2'd1);
      if (evt) m_ovf = 128; else if (m_ovf > 0) m_ovf--;
      if (evt && m_ren == 1) begin m_rst = 512; m_type = m_rsel; end
      else if (m_rst > 0) m_rst--;
      if (bw && bus_addr == 2'd1) m_cnt = lo;
      else if (tick && m_run == 1) m_cnt = (m_cnt + 1) % 256;
      if (ww && bus_addr == 2'd2 && hi == 'hA5 && lo == 0) m_flag = 0;
      if (ww && bus_addr == 2'd2 && hi == 'h5A) begin
        m_ren = (lo >> 6) & 1; m_rsel = (lo >> 5) & 1;
      end
      if (evt) m_flag = 1;
      if (bw && bus_addr == 2'd0) begin
        m_mode = (lo >> 6) & 1; m_run = (lo >> 5) & 1;
      end
    end
  end

  always @(negedge clk) begin
    if (live) begin
      chk(ovf_out == (m_ovf > 0), "R5 ovf_out vs model", ovf_out, m_ovf > 0);
      chk(irst_out == (m_rst > 0), "R6 irst_out vs model", irst_out, m_rst > 0);
      chk(irst_manual == m_type, "R6 irst_manual vs model", irst_manual, m_type);
      chk(bus_rdata == m_read(bus_addr), "R2 rdata vs model", bus_rdata, m_read(bus_addr));
    end
  end

  task automatic idle();
    bus_sel = 0; bus_wr = 0; bus_word = 0; tick = 0; ext_rst = 0;
  endtask

  task automatic wr(input bit word, input logic [1:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_word = word; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic rd(input logic [1:0] a, input int exp, input string req);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    chk(bus_rdata == exp[7:0], req, bus_rdata, exp);
  endtask

  task automatic ticks(input int n);
    @(posedge clk); #1; tick = 1;
    repeat (n) @(posedge clk);
    #1; tick = 0;
  endtask

  task automatic measure(input int span, output int n_ovf, output int n_rst,
                         output int first_ovf, output int first_rst, output int manual_seen);
    n_ovf = 0; n_rst = 0; first_ovf = -1; first_rst = -1; manual_seen = 0;
    for (int i = 0; i < span; i++) begin
      @(negedge clk);
      if (ovf_out) begin n_ovf++; if (first_ovf < 0) first_ovf = i; end
      if (irst_out) begin
        n_rst++; if (first_rst < 0) first_rst = i;
        if (irst_manual) manual_seen++;
      end
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int no, nr, fo, fr, ms;
    rst_n = 0; bus_addr = 0; bus_wdata = 0; idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1; live = 1;

    rd(2'd0, 'h00, "R1 ctrl after reset");
    rd(2'd1, 'h00, "R1 count after reset");
    rd(2'd3, 'h00, "R1 rctl after reset");
    chk(!ovf_out && !irst_out && !irst_manual, "R1 outputs low", {ovf_out, irst_out, irst_manual}, 0);

    wr(0, 2'd0, 16'h0060);
    rd(2'd0, 'h60, "R2 ctrl readback");
    wr(0, 2'd1, 16'h0010);
    rd(2'd1, 'h10, "R2 count readback");
    rd(2'd2, 'h00, "R2 offset 2 reads zero");

    ticks(5);
    rd(2'd1, 'h15, "R3 counts ticks");
    wr(0, 2'd0, 16'h0040);
    ticks(4);
    rd(2'd1, 'h15, "R3 holds when disabled");
    wr(0, 2'd0, 16'h0060);
    @(posedge clk); #1;
    tick = 1; bus_sel = 1; bus_wr = 1; bus_word = 0; bus_addr = 2'd1; bus_wdata = 16'h0033;
    @(posedge clk); #1; idle();
    rd(2'd1, 'h33, "R3 write beats tick");

    wr(1, 2'd2, 16'h5A60);
    rd(2'd3, 'h60, "R8 config key loads bits");

    wr(0, 2'd1, 16'h00FF);
    ticks(1);
    measure(600, no, nr, fo, fr, ms);
    chk(no == 128, "R5 overflow pulse length", no, 128);
    chk(nr == 512, "R6 reset pulse length", nr, 512);
    chk(fo == fr && fo == 0, "R6 pulses start together", fr, fo);
    chk(ms == 512, "R6 manual type held", ms, 512);
    rd(2'd1, 'h00, "R4 count wrapped");
    rd(2'd3, 'hE0, "R4 flag set on overflow");

    wr(0, 2'd3, 16'h0000);
    rd(2'd3, 'hE0, "R9 byte write offset 3 ignored");
    wr(0, 2'd2, 16'h0000);
    rd(2'd3, 'hE0, "R9 byte write offset 2 ignored");
    wr(1, 2'd2, 16'h1200);
    rd(2'd3, 'hE0, "R9 unknown key ignored");
    wr(1, 2'd2, 16'hA501);
    rd(2'd3, 'hE0, "R9 clear key nonzero low ignored");
    wr(1, 2'd0, 16'h5A00);
    rd(2'd0, 'h60, "R9 word write at ctrl ignored");
    rd(2'd3, 'hE0, "R9 key at wrong offset ignored");

    wr(1, 2'd2, 16'h5A20);
    rd(2'd3, 'hA0, "R8 flag kept by config key");
    wr(1, 2'd2, 16'hA500);
    rd(2'd3, 'h20, "R7 clear key keeps config");

    wr(0, 2'd1, 16'h00FF);
    ticks(1);
    measure(200, no, nr, fo, fr, ms);
    chk(no == 128, "R5 second overflow pulse", no, 128);
    chk(nr == 0, "R6 no reset when disabled", nr, 0);
    rd(2'd3, 'hA0, "R4 flag set again");

    wr(1, 2'd2, 16'hA500);
    wr(0, 2'd0, 16'h0020);
    wr(0, 2'd1, 16'h00FF);
    ticks(1);
    measure(150, no, nr, fo, fr, ms);
    chk(no == 0, "R4 interval wrap gives no pulse", no, 0);
    rd(2'd3, 'h20, "R4 interval wrap leaves flag");
    rd(2'd1, 'h00, "R4 interval wrap to zero");

    wr(0, 2'd0, 16'h0060);
    wr(0, 2'd1, 16'h00FF);
    @(posedge clk); #1;
    tick = 1; bus_sel = 1; bus_wr = 1; bus_word = 1; bus_addr = 2'd2; bus_wdata = 16'hA500;
    @(posedge clk); #1; idle();
    rd(2'd3, 'hA0, "R11 overflow beats clear");
    measure(150, no, nr, fo, fr, ms);

    wr(1, 2'd2, 16'h5A40);
    rd(2'd3, 'hC0, "R8 config with flag set");
    wr(1, 2'd2, 16'hA500);
    wr(0, 2'd1, 16'h00FF);
    @(posedge clk); #1;
    tick = 1; ext_rst = 1;
    @(posedge clk); #1; idle();
    @(negedge clk);
    chk(!ovf_out && !irst_out, "R10 ext reset beats overflow", {ovf_out, irst_out}, 0);
    rd(2'd3, 'h00, "R10 flag cleared by ext reset");
    rd(2'd0, 'h00, "R10 ctrl cleared by ext reset");

    wr(0, 2'd0, 16'h0060);
    wr(1, 2'd2, 16'h5A40);
    wr(0, 2'd1, 16'h00FF);
    ticks(1);
    repeat (10) @(negedge clk);
    chk(irst_out == 1'b1, "R6 reset pulse running", irst_out, 1);
    chk(irst_manual == 1'b0, "R6 power-on type", irst_manual, 0);
    @(posedge clk); #1; ext_rst = 1;
    @(posedge clk); #1; idle();
    @(negedge clk);
    chk(!ovf_out && !irst_out, "R10 ext reset ends pulses", {ovf_out, irst_out}, 0);

    repeat (4) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule